// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a virtual address into a physical address by reading page-table entries from memory, one level at a time. A request carries the virtual address, the access kind (fetch, load, store), the current privilege and four status bits: supervisor-user access, make-executable-readable, modify-privilege and the previous privilege. A configuration input selects the translation scheme and gives the root page number. Both are sampled when the request is accepted.

For each level the walker issues one read on a single-beat memory port and waits for the reply. A pointer entry moves the walk one level down. A leaf entry is checked against every permission rule. When the accessed or dirty flag has to change, the updated entry is written back to memory before the answer is given. The answer is a one-cycle pulse that carries the physical address and the read, write and execute rights, or a fault.

Top module: `ptw_top`

## Requirements
- R1: `cfg_mode` 0 is bare. It returns `resp_pa` equal to the low 56 address bits with all three rights set, makes no memory access, and answers in the cycle after acceptance. Code 3 is reserved and faults with no memory access. Code 1 selects the narrow scheme: two levels, 10-bit indices, 4-byte entries, and only the low 32 address bits are used. Code 2 selects the wide scheme: three levels, 9-bit indices, 8-byte entries.
- R2: Privilege codes are U=0, S=1, M=3. An access at M is passed through like bare. For a load or store (`req_acc` 1 or 2) at M with `req_mprv` set, the effective privilege is `req_mpp`. A fetch (`req_acc` 0) ignores `req_mprv`.
- R3: In the wide scheme, address bits 63..39 must all equal bit 38. If they do not, the request faults with no memory access.
- R4: The first entry address is (`cfg_root_ppn` << 12) plus the top index times the entry size. Indices are taken from the highest level down: narrow uses bits 31:22 then 21:12; wide uses 38:30, 29:21 and 20:12. A pointer sets the next base to its PPN (bits 10 and up: 22 bits narrow, 44 bits wide) shifted left by 12. Entry flag bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7.
- R5: An entry with V clear faults. A pointer (R, W and X all clear) met at the last level faults.
- R6: A leaf with W set and R clear (write-only or write+execute) faults.
- R7: A leaf with U set faults when the effective privilege is not U and either `req_sum` is clear or the access is a fetch. A leaf with U clear faults when the effective privilege is not S.
- R8: A leaf above the last level whose PPN has non-zero bits below the level shift (9 or 18 bits wide, 10 bits narrow) faults. Otherwise the physical address is the PPN OR'd with the virtual page bits below that shift, followed by the 12 offset bits.
- R9: A load needs R, or X together with `req_mxr`. A store needs W. A fetch needs X.
- R10: On success A is set, and D as well for a store. If the entry changed, it is written back to the address it was read from before the answer. An unchanged entry is not written.
- R11: The rights reported are: read is R or (X and MXR), execute is X, and write is W only for a store or when D was already set. A fault reports no rights.
- R12: `req_ready` is high only while idle. `resp_valid` and each memory request last one cycle. A memory reply is expected one or more cycles after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_mxr | input | 1 | Executable pages readable |
| req_mprv | input | 1 | Loads/stores use previous privilege |
| req_mpp | input | 2 | Previous privilege |
| cfg_mode | input | 2 | Translation scheme |
| cfg_root_ppn | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Memory request, one cycle |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_wide | output | 1 | Entry is 8 bytes (else 4) |
| mem_req_addr | output | 56 | Entry physical address |
| mem_req_wdata | output | 64 | Updated entry |
| mem_resp_valid | input | 1 | Memory reply |
| mem_resp_rdata | input | 64 | Entry read data |
| resp_valid | output | 1 | Answer pulse |
| resp_fault | output | 1 | Translation fault |
| resp_pa | output | 56 | Physical address |
| resp_r | output | 1 | Read right |
| resp_w | output | 1 | Write right |
| resp_x | output | 1 | Execute right |

## Verification
A wrong level counter or base register shows up in the address of the next memory read, one cycle after the previous reply. A wrong check is visible in the answer pulse. So the bench logs every read and write address and compares the read count and order for each walk. If the walker decides the dirty state wrongly, it issues a write-back when none is needed or misses one, and this is seen at the memory port before the answer. A stuck state machine leaves `req_ready` low and no answer arrives, which the per-request wait limit catches within a few hundred cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PG_OFF       = 12;
    localparam int LVL_W        = 2;
    localparam int IDXW_NARROW  = 10;
    localparam int IDXW_WIDE    = 9;
    localparam int LEVELS_NARROW = 2;
    localparam int LEVELS_WIDE  = 3;
    localparam int NARROW_BITS  = 32;
    localparam int WIDE_VA_BITS = PG_OFF + LEVELS_WIDE * IDXW_WIDE;   // 39
    localparam int VPN_WIDE_W   = WIDE_VA_BITS - PG_OFF;              // 27
    localparam int VPN_NARROW_W = NARROW_BITS - PG_OFF;               // 20
    localparam int PPN_LSB      = 10;
    localparam int PPN_NARROW_W = NARROW_BITS - PPN_LSB;              // 22

    localparam int F_V = 0;
    localparam int F_R = 1;
    localparam int F_W = 2;
    localparam int F_X = 3;
    localparam int F_U = 4;
    localparam int F_A = 6;
    localparam int F_D = 7;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [1:0] SCHEME_BARE   = 2'd0;
    localparam logic [1:0] SCHEME_NARROW = 2'd1;
    localparam logic [1:0] SCHEME_WIDE   = 2'd2;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WB_REQ, ST_WB_WAIT, ST_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_priv_resolve.sv
module ptw_priv_resolve
    import ptw_pkg::*;
(
    input  logic [1:0] priv,
    input  logic [1:0] acc,
    input  logic       mprv,
    input  logic [1:0] mpp,
    output logic [1:0] priv_eff,
    output logic       direct
);
    always_comb begin
        priv_eff = priv;
        if (priv == PRIV_M && acc != ACC_FETCH && mprv)
            priv_eff = mpp;
        direct = (priv_eff == PRIV_M);
    end
endmodule

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
    import ptw_pkg::*;
#(
    parameter int PA_W = 56
) (
    input  logic                  wide,
    input  logic [LVL_W-1:0]      level,
    input  logic [VPN_WIDE_W-1:0] vpn,
    input  logic [PA_W-1:0]       base,
    output logic [PA_W-1:0]       pte_addr
);
    logic [IDXW_WIDE-1:0]   idx_w [LEVELS_WIDE];
    logic [IDXW_NARROW-1:0] idx_n [LEVELS_NARROW];

    for (genvar g = 0; g < LEVELS_WIDE; g++) begin : g_wide_idx
        assign idx_w[g] = vpn[g*IDXW_WIDE +: IDXW_WIDE];
    end
    for (genvar g = 0; g < LEVELS_NARROW; g++) begin : g_narrow_idx
        assign idx_n[g] = vpn[g*IDXW_NARROW +: IDXW_NARROW];
    end

    logic [PA_W-1:0] offs;
    always_comb begin
        offs = '0;
        if (wide) begin
            if (int'(level) < LEVELS_WIDE)
                offs = PA_W'({idx_w[level], 3'b000});
        end else begin
            if (int'(level) < LEVELS_NARROW)
                offs = PA_W'({idx_n[level[0]], 2'b00});
        end
        pte_addr = base + offs;
    end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int PA_W  = 56,
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0]        pte,
    input  logic                    wide,
    input  logic [LVL_W-1:0]        level,
    input  logic [1:0]              acc,
    input  logic [1:0]              priv_eff,
    input  logic                    sum,
    input  logic                    mxr,
    input  logic [WIDE_VA_BITS-1:0] va,
    output logic                    invalid,
    output logic                    pointer,
    output logic                    leaf_fault,
    output logic [PA_W-PG_OFF-1:0]  ppn,
    output logic [PA_W-1:0]         pa,
    output logic                    perm_r,
    output logic                    perm_w,
    output logic                    perm_x,
    output logic [PTE_W-1:0]        pte_new,
    output logic                    need_wb
);
    localparam int PPN_W = PA_W - PG_OFF;

    logic fr, fw, fx, fu, fd;
    logic [4:0] sh;
    logic [PPN_W-1:0] mask, vpn;
    logic rsv, u_bad, s_bad, misal, acc_bad;

    always_comb begin
        fr = pte[F_R];
        fw = pte[F_W];
        fx = pte[F_X];
        fu = pte[F_U];
        fd = pte[F_D];
        invalid = !pte[F_V];
        pointer = pte[F_V] && !fr && !fw && !fx;

        if (wide) begin
            ppn = pte[PPN_LSB +: PPN_W];
            vpn = PPN_W'(va[PG_OFF +: VPN_WIDE_W]);
            case (level)
                2'd1:    sh = 5'(IDXW_WIDE);
                2'd2:    sh = 5'(2*IDXW_WIDE);
                default: sh = 5'd0;
            endcase
        end else begin
            ppn = PPN_W'(pte[PPN_LSB +: PPN_NARROW_W]);
            vpn = PPN_W'(va[PG_OFF +: VPN_NARROW_W]);
            sh  = (level == 2'd1) ? 5'(IDXW_NARROW) : 5'd0;
        end
        mask = (PPN_W'(1) << sh) - PPN_W'(1);

        rsv     = fw && !fr;
        u_bad   = fu && (priv_eff != PRIV_U) && (!sum || acc == ACC_FETCH);
        s_bad   = !fu && (priv_eff != PRIV_S);
        misal   = |(ppn & mask);
        case (acc)
            ACC_LOAD:  acc_bad = !(fr || (fx && mxr));
            ACC_STORE: acc_bad = !fw;
            default:   acc_bad = !fx;
        endcase
        leaf_fault = rsv || u_bad || s_bad || misal || acc_bad;

        pa     = {ppn | (vpn & mask), va[PG_OFF-1:0]};
        perm_r = fr || (fx && mxr);
        perm_x = fx;
        perm_w = fw && (acc == ACC_STORE || fd);

        pte_new = pte;
        pte_new[F_A] = 1'b1;
        if (acc == ACC_STORE)
            pte_new[F_D] = 1'b1;
        need_wb = (pte_new != pte);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 56,
    parameter int PTE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              req_sum,
    input  logic              req_mxr,
    input  logic              req_mprv,
    input  logic [1:0]        req_mpp,
    input  logic [1:0]        cfg_mode,
    input  logic [PA_W-PG_OFF-1:0] cfg_root_ppn,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic              mem_req_wide,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [PTE_W-1:0]  mem_resp_rdata,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [PA_W-1:0]   resp_pa,
    output logic              resp_r,
    output logic              resp_w,
    output logic              resp_x
);
    localparam int PPN_W  = PA_W - PG_OFF;
    localparam int VA_TOP = WIDE_VA_BITS - 1;

    typedef struct packed {
        walk_state_e     st;
        logic [LVL_W-1:0] level;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] addr;
        logic [PTE_W-1:0] pte;
        logic [VA_W-1:0] va;
        logic [1:0]      acc;
        logic [1:0]      priv;
        logic            sum;
        logic            mxr;
        logic            wide;
        logic            fault;
        logic [PA_W-1:0] pa;
        logic            r;
        logic            w;
        logic            x;
    } walk_t;

    walk_t q, d;

    logic [1:0] priv_eff;
    logic       direct;
    ptw_priv_resolve u_priv (
        .priv     (req_priv),
        .acc      (req_acc),
        .mprv     (req_mprv),
        .mpp      (req_mpp),
        .priv_eff (priv_eff),
        .direct   (direct)
    );

    logic [PA_W-1:0] pte_addr;
    ptw_index_gen #(.PA_W(PA_W)) u_idx (
        .wide     (q.wide),
        .level    (q.level),
        .vpn      (q.va[PG_OFF +: VPN_WIDE_W]),
        .base     (q.base),
        .pte_addr (pte_addr)
    );

    logic [PTE_W-1:0] rd_pte;
    assign rd_pte = q.wide ? mem_resp_rdata : PTE_W'(mem_resp_rdata[NARROW_BITS-1:0]);

    logic             lf_invalid, lf_pointer, lf_fault, lf_r, lf_w, lf_x, lf_wb;
    logic [PPN_W-1:0] lf_ppn;
    logic [PA_W-1:0]  lf_pa;
    logic [PTE_W-1:0] lf_new;
    ptw_leaf_eval #(.PA_W(PA_W), .PTE_W(PTE_W)) u_leaf (
        .pte        (rd_pte),
        .wide       (q.wide),
        .level      (q.level),
        .acc        (q.acc),
        .priv_eff   (q.priv),
        .sum        (q.sum),
        .mxr        (q.mxr),
        .va         (q.va[WIDE_VA_BITS-1:0]),
        .invalid    (lf_invalid),
        .pointer    (lf_pointer),
        .leaf_fault (lf_fault),
        .ppn        (lf_ppn),
        .pa         (lf_pa),
        .perm_r     (lf_r),
        .perm_w     (lf_w),
        .perm_x     (lf_x),
        .pte_new    (lf_new),
        .need_wb    (lf_wb)
    );

    logic canonical;
    assign canonical = (&req_va[VA_W-1:VA_TOP]) || !(|req_va[VA_W-1:VA_TOP]);

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_va;
                    d.acc   = req_acc;
                    d.priv  = priv_eff;
                    d.sum   = req_sum;
                    d.mxr   = req_mxr;
                    d.wide  = (cfg_mode == SCHEME_WIDE);
                    d.fault = 1'b0;
                    d.pa    = '0;
                    d.r     = 1'b0;
                    d.w     = 1'b0;
                    d.x     = 1'b0;
                    if (cfg_mode == SCHEME_BARE || (direct && cfg_mode != 2'd3)) begin
                        d.st = ST_DONE;
                        d.pa = req_va[PA_W-1:0];
                        d.r  = 1'b1;
                        d.w  = 1'b1;
                        d.x  = 1'b1;
                    end else if (cfg_mode == 2'd3 ||
                                 (cfg_mode == SCHEME_WIDE && !canonical)) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                    end else begin
                        d.st    = ST_RD_REQ;
                        d.level = (cfg_mode == SCHEME_WIDE) ? LVL_W'(LEVELS_WIDE-1)
                                                            : LVL_W'(LEVELS_NARROW-1);
                        d.base  = {cfg_root_ppn, {PG_OFF{1'b0}}};
                    end
                end
            end
            ST_RD_REQ: begin
                d.addr = pte_addr;
                d.st   = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_resp_valid) begin
                    if (lf_invalid) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                    end else if (lf_pointer) begin
                        if (q.level == '0) begin
                            d.st    = ST_DONE;
                            d.fault = 1'b1;
                        end else begin
                            d.level = q.level - LVL_W'(1);
                            d.base  = {lf_ppn, {PG_OFF{1'b0}}};
                            d.st    = ST_RD_REQ;
                        end
                    end else if (lf_fault) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                    end else begin
                        d.pa  = lf_pa;
                        d.r   = lf_r;
                        d.w   = lf_w;
                        d.x   = lf_x;
                        d.pte = lf_new;
                        d.st  = lf_wb ? ST_WB_REQ : ST_DONE;
                    end
                end
            end
            ST_WB_REQ:  d.st = ST_WB_WAIT;
            ST_WB_WAIT: if (mem_resp_valid) d.st = ST_DONE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_RD_REQ) || (q.st == ST_WB_REQ);
    assign mem_req_write = (q.st == ST_WB_REQ);
    assign mem_req_wide  = q.wide;
    assign mem_req_addr  = (q.st == ST_WB_REQ) ? q.addr : pte_addr;
    assign mem_req_wdata = q.pte;
    assign resp_valid    = (q.st == ST_DONE);
    assign resp_fault    = q.fault;
    assign resp_pa       = q.pa;
    assign resp_r        = q.r;
    assign resp_w        = q.w;
    assign resp_x        = q.x;

    // R12: answer is a single-cycle pulse
    a_r12_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R12: each memory request lasts one cycle
    a_r12_mem_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R12: no new request is taken while memory is in use
    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R11: a fault carries no rights
    a_r11_fault_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> !(resp_r || resp_w || resp_x));
    // R10: a write-back directly follows a read reply
    a_r10_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> $past(mem_resp_valid));
    // R10: the write-back goes to the address just read
    a_r10_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_addr == $past(mem_req_addr, 2));
endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        req_mprv = 1'b0;
    logic [1:0]  req_mpp = '0;
    logic [1:0]  cfg_mode = '0;
    logic [43:0] cfg_root_ppn = '0;
    logic        mem_req_valid, mem_req_write, mem_req_wide;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [63:0] mem_resp_rdata = '0;
    logic        resp_valid, resp_fault, resp_r, resp_w, resp_x;
    logic [55:0] resp_pa;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_acc(req_acc), .req_priv(req_priv), .req_sum(req_sum),
        .req_mxr(req_mxr), .req_mprv(req_mprv), .req_mpp(req_mpp),
        .cfg_mode(cfg_mode), .cfg_root_ppn(cfg_root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_wide(mem_req_wide), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
        .resp_r(resp_r), .resp_w(resp_w), .resp_x(resp_x)
    );

    logic [63:0] mem [logic [63:0]];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [63:0] rd_log [8];
    logic [63:0] wr_addr = '0;
    logic [63:0] wr_data = '0;

    always @(posedge clk) begin
        mem_resp_valid <= 1'b0;
        if (rst_n && mem_req_valid) begin
            mem_resp_valid <= 1'b1;
            if (mem_req_write) begin
                mem[64'(mem_req_addr)] = mem_req_wdata;
                wr_addr = 64'(mem_req_addr);
                wr_data = mem_req_wdata;
                wr_cnt  = wr_cnt + 1;
            end else begin
                mem_resp_rdata <= mem.exists(64'(mem_req_addr)) ? mem[64'(mem_req_addr)] : 64'd0;
                if (rd_cnt < 8) rd_log[rd_cnt] = 64'(mem_req_addr);
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    int n_checks = 0;
    int n_errors = 0;
    logic        g_fault;
    logic [55:0] g_pa;
    logic [2:0]  g_rwx;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] priv,
                        input logic sum, input logic mxr, input logic mprv, input logic [1:0] mpp);
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        req_va = va; req_acc = acc; req_priv = priv; req_sum = sum;
        req_mxr = mxr; req_mprv = mprv; req_mpp = mpp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !resp_valid; i++) @(negedge clk);
        g_fault = resp_fault;
        g_pa    = resp_pa;
        g_rwx   = {resp_r, resp_w, resp_x};
        chk(resp_valid == 1'b1, "R12 answer arrives", 64'(resp_valid), 64'd1);
    endtask

    function automatic logic [63:0] va39(input int v2, input int v1, input int v0, input int off);
        return (64'(v2) << 30) | (64'(v1) << 21) | (64'(v0) << 12) | 64'(off);
    endfunction

    task automatic t_reset;
        chk(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R12 no answer after reset", 64'(resp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R12 no memory request after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_bare;
        cfg_mode = 2'd0;
        @(negedge clk);
        rd_cnt = 0;
        req_va = 64'hAB12_3456_789A_BCDE; req_acc = 2'd2; req_priv = 2'd0;
        req_mprv = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, "R1 bare answers next cycle", 64'(resp_valid), 64'd1);
        chk(resp_pa == 56'h12_3456_789A_BCDE, "R1 bare address", 64'(resp_pa), 64'h12_3456_789A_BCDE);
        chk({resp_r, resp_w, resp_x} == 3'b111 && !resp_fault, "R1 bare rights", 64'({resp_fault, resp_r, resp_w, resp_x}), 64'h7);
        chk(rd_cnt == 0, "R1 bare no memory", 64'(rd_cnt), 64'd0);
        cfg_mode = 2'd3;
        walk(64'h1000, 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && rd_cnt == 0, "R1 reserved scheme faults", 64'({g_fault, 8'(rd_cnt)}), 64'h100);
    endtask

    task automatic t_wide_walk;
        cfg_mode = 2'd2;
        cfg_root_ppn = 44'h100;
        walk(va39(1, 2, 3, 'h45), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(!g_fault && g_pa == 56'h1234_5045, "R8 leaf address", 64'(g_pa), 64'h1234_5045);
        chk(rd_cnt == 3 && rd_log[0] == 64'h100008 && rd_log[1] == 64'h200010 && rd_log[2] == 64'h300018,
            "R4 entry addresses", rd_log[2], 64'h300018);
        chk(g_rwx == 3'b110, "R11 rights with dirty page", 64'(g_rwx), 64'h6);
        chk(wr_cnt == 0, "R10 no write when unchanged", 64'(wr_cnt), 64'd0);
    endtask

    task automatic t_dirty;
        walk(va39(1, 2, 4, 'h10), 2'd2, 2'd1, 0, 0, 0, 2'd0);
        chk(!g_fault && g_pa == 56'h55010, "R10 store address", 64'(g_pa), 64'h55010);
        chk(wr_cnt == 1 && wr_addr == 64'h300020, "R10 write-back address", wr_addr, 64'h300020);
        chk(wr_data == ((64'h55 << 10) | 64'hC7), "R10 write-back value", wr_data, (64'h55 << 10) | 64'hC7);
        walk(va39(1, 2, 5, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(!g_fault && g_rwx == 3'b100, "R11 load on clean page has no write", 64'(g_rwx), 64'h4);
    endtask

    task automatic t_mprv;
        walk(va39(1, 2, 3, 'h45), 2'd1, 2'd3, 0, 0, 1, 2'd1);
        chk(!g_fault && g_pa == 56'h1234_5045, "R2 load uses previous privilege S", 64'(g_pa), 64'h1234_5045);
        walk(va39(1, 2, 3, 'h45), 2'd1, 2'd3, 0, 0, 1, 2'd0);
        chk(g_fault, "R2 previous privilege U on supervisor page faults", 64'(g_fault), 64'd1);
        walk(64'h0000_0012_3456_7890, 2'd0, 2'd3, 0, 0, 1, 2'd0);
        chk(!g_fault && g_pa == 56'h12_3456_7890 && rd_cnt == 0 && g_rwx == 3'b111,
            "R2 fetch ignores previous privilege", 64'(g_pa), 64'h12_3456_7890);
    endtask

    task automatic t_canonical;
        walk(64'h0000_0040_0000_0000, 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && rd_cnt == 0, "R3 non-canonical faults", 64'({g_fault, 8'(rd_cnt)}), 64'h100);
        walk(64'hFFFF_FFC0_0000_0000, 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(rd_cnt == 1, "R3 sign-extended address walks", 64'(rd_cnt), 64'd1);
    endtask

    task automatic t_invalid;
        walk(va39(1, 2, 6, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && g_rwx == 3'b000, "R5 invalid entry faults with no rights", 64'({g_fault, g_rwx}), 64'h8);
        walk(va39(1, 2, 7, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && rd_cnt == 3, "R5 pointer at last level faults", 64'({g_fault, 8'(rd_cnt)}), 64'h103);
    endtask

    task automatic t_reserved;
        walk(va39(1, 2, 8, 0), 2'd2, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && wr_cnt == 0, "R6 write-only faults", 64'(g_fault), 64'd1);
        walk(va39(1, 2, 9, 0), 2'd0, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault, "R6 write+execute faults", 64'(g_fault), 64'd1);
    endtask

    task automatic t_user;
        walk(va39(1, 2, 10, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault, "R7 supervisor on user page without SUM", 64'(g_fault), 64'd1);
        walk(va39(1, 2, 10, 'h8), 2'd1, 2'd1, 1, 0, 0, 2'd0);
        chk(!g_fault && g_pa == 56'h77008 && g_rwx == 3'b101, "R7 supervisor with SUM", 64'(g_pa), 64'h77008);
        walk(va39(1, 2, 10, 0), 2'd1, 2'd0, 0, 0, 0, 2'd0);
        chk(!g_fault, "R7 user on user page", 64'(g_fault), 64'd0);
        walk(va39(1, 2, 10, 0), 2'd0, 2'd1, 1, 0, 0, 2'd0);
        chk(g_fault, "R7 supervisor fetch on user page", 64'(g_fault), 64'd1);
        walk(va39(1, 2, 3, 0), 2'd1, 2'd0, 0, 0, 0, 2'd0);
        chk(g_fault, "R7 user on supervisor page", 64'(g_fault), 64'd1);
    endtask

    task automatic t_superpage;
        walk(va39(1, 3, 'h1AB, 'h321), 2'd0, 2'd1, 0, 0, 0, 2'd0);
        chk(!g_fault && g_pa == 56'h5A_B321 && rd_cnt == 2, "R8 superpage address", 64'(g_pa), 64'h5A_B321);
        chk(g_rwx == 3'b101, "R11 superpage rights", 64'(g_rwx), 64'h5);
        walk(va39(1, 4, 0, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault, "R8 misaligned superpage", 64'(g_fault), 64'd1);
    endtask

    task automatic t_access;
        walk(va39(1, 2, 11, 0), 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault, "R9 load of execute-only without MXR", 64'(g_fault), 64'd1);
        walk(va39(1, 2, 11, 4), 2'd1, 2'd1, 0, 1, 0, 2'd0);
        chk(!g_fault && g_rwx == 3'b101, "R9 load of execute-only with MXR", 64'(g_rwx), 64'h5);
        walk(va39(1, 2, 12, 0), 2'd2, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault && wr_cnt == 0, "R9 store to read-only", 64'(g_fault), 64'd1);
        walk(va39(1, 2, 3, 0), 2'd0, 2'd1, 0, 0, 0, 2'd0);
        chk(g_fault, "R9 fetch from non-executable", 64'(g_fault), 64'd1);
    endtask

    task automatic t_narrow;
        cfg_mode = 2'd1;
        cfg_root_ppn = 44'h10;
        walk(64'hFFFF_FFFF_0080_509A, 2'd1, 2'd1, 0, 0, 0, 2'd0);
        chk(!g_fault && g_pa == 56'h3_FFFF_F09A, "R1 narrow scheme address", 64'(g_pa), 64'h3_FFFF_F09A);
        chk(rd_cnt == 2 && rd_log[0] == 64'h10008 && rd_log[1] == 64'h20014,
            "R4 narrow entry addresses", rd_log[1], 64'h20014);
    endtask

    initial begin
        mem[64'h100008] = (64'h200 << 10) | 64'h01;
        mem[64'h200010] = (64'h300 << 10) | 64'h01;
        mem[64'h200018] = (64'h400 << 10) | 64'h4B;
        mem[64'h200020] = (64'h401 << 10) | 64'h4B;
        mem[64'h300018] = (64'h12345 << 10) | 64'hC7;
        mem[64'h300020] = (64'h55 << 10) | 64'h07;
        mem[64'h300028] = (64'h66 << 10) | 64'h47;
        mem[64'h300038] = (64'h400 << 10) | 64'h01;
        mem[64'h300040] = (64'h10 << 10) | 64'h45;
        mem[64'h300048] = (64'h10 << 10) | 64'h4D;
        mem[64'h300050] = (64'h77 << 10) | 64'hDB;
        mem[64'h300058] = (64'h88 << 10) | 64'h49;
        mem[64'h300060] = (64'h99 << 10) | 64'hC3;
        mem[64'h10008]  = (64'h20 << 10) | 64'h01;
        mem[64'h20014]  = (64'h3FFFFF << 10) | 64'hC7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bare();
        t_wide_walk();
        t_dirty();
        t_mprv();
        t_canonical();
        t_invalid();
        t_reserved();
        t_user();
        t_superpage();
        t_access();
        t_narrow();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule